// File: doc/BRIEF.md
# DRAM Controller with Refresh Arbitration

This controller connects a simple processor request port to a single one-bit-wide DRAM whose cells form a square array of rows and columns. By default the array is 512 rows by 512 columns. A request carries a full cell address, a read/write flag and one data bit. The controller splits the address into a row half and a column half and drives them one after the other on a half-width address bus. The row half goes out with the row strobe and the column half with the column strobe. Access time and precharge time are counted in clock cycles. Every access ends with a mandatory precharge, so one cycle costs the access time plus the precharge time.

A free-running interval timer raises a refresh request once per refresh slot. The default slot is 780 cycles, about 7.8 us at 100 MHz, which covers all 512 rows within 4 ms. Each refresh is a row-strobe-only cycle on the row named by an internal wrapping counter. When a refresh is pending, it wins against a new processor request. It never cuts short an access that is already running. The processor holds its request until the controller is ready again.

Top module: `dram_ctrl`

## Requirements
- R1: For a processor access at address A, the row strobe falls with A[ROW_W+COL_W-1:COL_W] on the address pins, and the column strobe falls with A[COL_W-1:0] on the address pins.
- R2: In every cycle the row strobe stays low for exactly T_ACC clocks. For an access, the column strobe falls one clock after the row strobe.
- R3: For a write, write-enable is low and the data bit is valid from the clock where the row strobe falls, which is before the column strobe falls. The addressed cell then holds that bit.
- R4: rsp_done is a one-clock pulse in the clock after the last access clock, T_ACC+1 clocks after the accepting edge. For a read, rsp_rdata then holds the bit the DRAM drove in the last access clock.
- R5: Between two row-strobe low periods, the row strobe stays high for at least T_PRE clocks.
- R6: Refresh cycles occur once per REF_CYC clocks. Each is row-strobe-only: the column strobe and write-enable stay high.
- R7: The refresh row starts at 0 after reset, goes up by one after each refresh, and wraps from the last row to 0.
- R8: A pending refresh keeps req_ready low and is served before a waiting processor request. That request is served afterwards with correct data.
- R9: After reset all strobes are high, rsp_done is low and req_ready is high. An access starts only on a clock edge where req_valid and req_ready are both high. While req_valid is low, no processor access occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Cell address, row in the upper bits |
| req_wdata | input | 1 | Write data bit |
| rsp_rdata | output | 1 | Read data bit, valid with rsp_done |
| rsp_done | output | 1 | One-clock completion pulse |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data bit to the DRAM |
| dram_dout | input | 1 | Data bit from the DRAM |

## Verification
The bench builds the controller with an 8 x 8 array (ROW_W=3, COL_W=3), T_ACC=3, T_PRE=2 and REF_CYC=40. With only 64 cells, every address can be written and read back in two passes with complementary patterns. A pin-level DRAM model and monitor check each strobe period and the row and column placement. Because the refresh slot is short, the refresh counter wraps several times during the sweeps. Back-to-back requests also collide with pending refreshes many times, which exercises the arbitration path.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int T_ACC   = 5,
  parameter int T_PRE   = 5,
  parameter int REF_CYC = 780
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  output logic                   rsp_rdata,
  output logic                   rsp_done,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_din,
  input  logic                   dram_dout
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_MAX  = (T_ACC > T_PRE) ? T_ACC : T_PRE;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam int RT_W   = $clog2(REF_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REF, S_PRE} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  a_q;
  logic               wr_q, wd_q, rd_q, done_q;
  logic [RT_W-1:0]    rtmr;
  logic               rpend;
  logic [ROW_W-1:0]   rrow;

  logic acc_last, ref_last, pre_last, tick, col_phase;
  logic [PIN_W-1:0] row_pins, col_pins, ref_pins;

  assign acc_last  = (cnt == CNT_W'(T_ACC - 1));
  assign ref_last  = (st == S_REF) && acc_last;
  assign pre_last  = (cnt == CNT_W'(T_PRE - 1));
  assign tick      = (rtmr == RT_W'(REF_CYC - 1));
  assign col_phase = (st == S_ACC) && (cnt != '0);

  assign row_pins = PIN_W'(a_q[ADDR_W-1:COL_W]);
  assign col_pins = PIN_W'(a_q[COL_W-1:0]);
  assign ref_pins = PIN_W'(rrow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtmr  <= '0;
      rpend <= 1'b0;
    end else begin
      rtmr  <= tick ? '0 : rtmr + 1'b1;
      rpend <= tick | (rpend & ~(st == S_IDLE));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      rrow   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (rpend) begin
            st <= S_REF;
          end else if (req_valid) begin
            st   <= S_ACC;
            a_q  <= req_addr;
            wr_q <= req_write;
            wd_q <= req_wdata;
          end
        end
        S_ACC: begin
          if (acc_last) begin
            if (!wr_q) rd_q <= dram_dout;
            done_q <= 1'b1;
            cnt    <= '0;
            st     <= S_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REF: begin
          if (acc_last) begin
            rrow <= rrow + 1'b1;
            cnt  <= '0;
            st   <= S_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (pre_last) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE) && !rpend;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rd_q;
  assign dram_ras_n = !((st == S_ACC) || (st == S_REF));
  assign dram_cas_n = !col_phase;
  assign dram_we_n  = !((st == S_ACC) && wr_q);
  assign dram_din   = wd_q;
  assign dram_addr  = (st == S_REF) ? ref_pins : (col_phase ? col_pins : row_pins);

  logic [CNT_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          hi_cnt <= CNT_W'(T_PRE);
    else if (dram_ras_n) hi_cnt <= (hi_cnt < CNT_W'(T_PRE)) ? hi_cnt + 1'b1 : hi_cnt;
    else                 hi_cnt <= '0;
  end

  initial if (T_ACC < 2 || T_PRE < 1) $error("dram_ctrl: T_ACC must be >= 2 and T_PRE >= 1");

  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (!dram_ras_n && $past(!dram_ras_n))); // R2
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= CNT_W'(T_PRE))); // R5
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REF) |-> (dram_cas_n && dram_we_n)); // R6
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> $fell(dram_ras_n)); // R9
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int RW = 3, CW = 3, TA = 3, TP = 2, RC = 40;
  localparam int AW = RW + CW, PW = 3, N = 1 << AW, NR = 1 << RW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_rdata, rsp_done;
  logic [PW-1:0] dram_addr;
  logic ras_n, cas_n, we_n, din, dout;

  dram_ctrl #(.ROW_W(RW), .COL_W(CW), .T_ACC(TA), .T_PRE(TP), .REF_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_din(din), .dram_dout(dout));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic mem [0:N-1];
  logic [PW-1:0] row_l = '0;
  logic prev_ras_m = 1'b1;
  always @(posedge clk) begin
    if (!ras_n && prev_ras_m) row_l <= dram_addr;
    if (!ras_n && !cas_n && !we_n) mem[{row_l, dram_addr}] <= din;
    prev_ras_m <= ras_n;
  end
  assign dout = !cas_n ? mem[{row_l, dram_addr}] : 1'b0;

  int run_len = 0, hi_len = 100, nref = 0, nproc = 0, arb_hits = 0, cyc = 0;
  int exp_ref = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0, valid_at_start = 1'b0;
  logic [PW-1:0] run_row, run_col, last_row, last_col;
  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!ras_n) begin
        if (prev_ras) begin
          chk(hi_len >= TP, "R5 precharge", hi_len, TP);
          run_len = 1; run_row = dram_addr; cas_seen = 1'b0; valid_at_start = req_valid;
        end else run_len++;
        if (!cas_n && prev_cas) begin
          chk(run_len == 2, "R2 cas delay", run_len, 2);
          run_col = dram_addr;
        end
        if (!cas_n) cas_seen = 1'b1;
      end else begin
        if (!prev_ras) begin
          chk(run_len == TA, "R2/R6 ras low length", run_len, TA);
          if (cas_seen) begin
            nproc++; last_row = run_row; last_col = run_col;
          end else begin
            chk(int'(run_row) == exp_ref, "R7 refresh row", run_row, exp_ref);
            exp_ref = (exp_ref + 1) % NR;
            nref++;
            if (valid_at_start) arb_hits++;
          end
          hi_len = 1;
        end else hi_len++;
      end
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input bit d, output bit q);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!rsp_done && k < 50) begin @(negedge clk); k++; end
    chk(k == TA + 1, "R4 done latency", k, TA + 1);
    q = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R4 done one clock", rsp_done, 0);
    chk({last_row, last_col} == a, "R1 row/col split", {last_row, last_col}, a);
  endtask

  function automatic bit pat(input int a, input int p);
    return bit'(((a >> 0) ^ (a >> 3) ^ (a >> 5) ^ ((a >> 2) & (a >> 4)) ^ p) & 1);
  endfunction

  bit finished = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit q;
    int n0;
    for (int i = 0; i < N; i++) mem[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n, "R9 reset strobes", {ras_n, cas_n, we_n}, 7);
    chk(!rsp_done, "R9 reset done", rsp_done, 0);
    chk(req_ready, "R9 reset ready", req_ready, 1);
    n0 = nproc;
    repeat (30) @(negedge clk);
    chk(nproc == n0, "R9 no access without valid", nproc, n0);
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < N; a++) access(1'b1, AW'(a), pat(a, p), q);
      for (int a = 0; a < N; a++) begin
        access(1'b0, AW'(a), 1'b0, q);
        chk(q == pat(a, p), "R3/R4 read data", q, pat(a, p));
      end
    end
    repeat (5) @(negedge clk);
    chk(nref >= cyc / RC - 1 && nref <= cyc / RC, "R6 refresh rate", nref, cyc / RC);
    chk(nref > NR, "R7 refresh counter wrapped", nref, NR + 1);
    chk(arb_hits > 0, "R8 refresh served before waiting request", arb_hits, 1);
    chk(nproc == 4 * N, "R8 all requests served", nproc, 4 * N);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule